// File: doc/BRIEF.md
# Selectable Packet-Switching Link Flow Controller

This block sits on one link between two router stages. Flits arrive from the upstream stage and are tagged head, body or tail. They are written into a local flit buffer. Each cycle the controller decides whether the flit at the front of that buffer may cross the link. Free space in the downstream stage is tracked by a credit counter. The counter starts at the downstream buffer depth, loses one credit for each flit sent and gains one for each credit the downstream stage hands back.

A two-bit mode input selects the forwarding rule used for a packet's head:

- **Store-and-forward** waits until the entire packet sits in the local buffer and the downstream stage can hold all of it.
- **Virtual cut-through** lets the head go as soon as the downstream stage can hold the entire packet, even if the tail has not arrived yet.
- **Wormhole** moves any flit that has a single free downstream slot.

Once a head has crossed, the link belongs to that packet until its tail crosses. The mode input is consulted only for a head at the front of the buffer while no packet is open. Packet length, buffer depths and data width are parameters, with a default of four flits per packet.

Top module: `lfc_link_ctrl`

## Requirements
- R1: While reset is held and after its release, out_valid is 0 and in_ready is 1, and the credit count equals DS_DEPTH.
- R2: In mode 0 (store-and-forward), a head is not forwarded until its tail is in the local buffer and at least PKT_LEN credits are held. With full credits and back-to-back input, the head appears on the output PKT_LEN cycles after the edge that accepted it.
- R3: In mode 1 (cut-through), a head leaves before its tail has arrived when at least PKT_LEN credits are held. It appears on the output one cycle after the edge that accepted it.
- R4: In mode 1, a head is held while fewer than PKT_LEN credits are held. It leaves on the edge after the one at which the count reaches PKT_LEN, and is visible on the output one cycle after that.
- R5: In mode 2 or 3 (wormhole), any flit is forwarded whenever at least one credit is held, with one cycle of latency. With zero credits nothing leaves.
- R6: The credit count drops by one for each flit sent and rises by one for each cycle with credit_ret high. As a result, sent flits not yet returned never exceed DS_DEPTH.
- R7: Flits leave in arrival order with their kind and data unchanged. After a head has crossed, no other head crosses before that packet's tail. Kind codes are: 1 head, 0 body, 2 tail.
- R8: in_ready is 0 whenever the buffer holds BUF_DEPTH flits. A flit offered on in_valid at that time is not taken and never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Forwarding rule: 0 store-and-forward, 1 cut-through, 2 or 3 wormhole |
| in_valid | input | 1 | Upstream offers a flit |
| in_kind | input | 2 | Kind of the offered flit (1 head, 0 body, 2 tail) |
| in_data | input | DATA_W | Payload of the offered flit |
| in_ready | output | 1 | Local buffer has room; a flit is taken when in_valid and in_ready are both high at an edge |
| credit_ret | input | 1 | Downstream returns one buffer slot this cycle |
| out_valid | output | 1 | A flit crosses the link this cycle (registered) |
| out_kind | output | 2 | Kind of the crossing flit |
| out_data | output | DATA_W | Payload of the crossing flit |

## Verification
The embedded assertions check the following on every cycle:
- the credit count stays between zero and the downstream depth;
- a flit is never sent without a credit;
- the buffer is never written when full or read when empty;
- no second head crosses while a packet is open;
- a tail is only sent when a tail is held locally;
- a store-and-forward head only leaves with a complete packet behind it;
- a cut-through head only leaves with whole-packet room downstream.

The exact cycle costs can only be shown by the bench's scenarios:
- store-and-forward costing a packet length per hop while the other modes cost one cycle;
- a cut-through head stalling on two free slots and releasing one cycle after the last needed credit;
- a wormhole packet pausing mid-body at zero credits;
- a full buffer refusing further flits.

Order preservation under random modes, gaps and credit timing is also shown only by the bench's scenarios.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    FK_BODY = 2'd0,
    FK_HEAD = 2'd1,
    FK_TAIL = 2'd2,
    FK_RSVD = 2'd3
  } flit_kind_e;

  typedef enum logic [1:0] {
    FM_SAF    = 2'd0,
    FM_VCT    = 2'd1,
    FM_WH     = 2'd2,
    FM_WH_ALT = 2'd3
  } fwd_mode_e;

endpackage

// File: rtl/lfc_flit_fifo.sv
module lfc_flit_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage array without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  // R8: never written beyond capacity, never read when empty
  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r8_no_read_when_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/lfc_credit_ctr.sv
module lfc_credit_ctr #(
  parameter int DS_DEPTH = 8,
  parameter int CW       = $clog2(DS_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] credits
);
  localparam logic [CW-1:0] FULL = CW'(DS_DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      credits <= FULL;
    end else begin
      case ({take, give})
        2'b10:   credits <= credits - CW'(1);
        2'b01:   credits <= (credits != FULL) ? credits + CW'(1) : credits;
        default: credits <= credits;
      endcase
    end
  end

  // R6: count stays within downstream capacity
  a_r6_credit_ceiling: assert property (@(posedge clk) disable iff (rst)
    credits <= FULL);
  // R5: a flit is only sent while a downstream slot is known free
  a_r5_send_needs_credit: assert property (@(posedge clk) disable iff (rst)
    take |-> credits != '0);

endmodule

// File: rtl/lfc_pkt_tracker.sv
module lfc_pkt_tracker #(
  parameter int BUF_DEPTH = 8,
  parameter int NW        = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_tail,
  input  logic          pop_head,
  input  logic          pop_tail,
  output logic [NW-1:0] whole_pkts,
  output logic          in_pkt
);
  // whole_pkts: tails held locally, i.e. packets fully present
  always_ff @(posedge clk) begin
    if (rst) begin
      whole_pkts <= '0;
    end else begin
      case ({push_tail, pop_tail})
        2'b10:   whole_pkts <= whole_pkts + NW'(1);
        2'b01:   whole_pkts <= whole_pkts - NW'(1);
        default: whole_pkts <= whole_pkts;
      endcase
    end
  end

  // in_pkt: link is owned by a packet whose head crossed and tail has not
  always_ff @(posedge clk) begin
    if (rst)           in_pkt <= 1'b0;
    else if (pop_tail) in_pkt <= 1'b0;
    else if (pop_head) in_pkt <= 1'b1;
  end

  // R7: no second head while a packet owns the link
  a_r7_single_open_packet: assert property (@(posedge clk) disable iff (rst)
    pop_head |-> !in_pkt);
  // R7: a tail only crosses to close an open packet
  a_r7_tail_closes_open: assert property (@(posedge clk) disable iff (rst)
    pop_tail |-> in_pkt);
  // R2: a departing tail must have been counted as present
  a_r2_tail_was_held: assert property (@(posedge clk) disable iff (rst)
    pop_tail |-> whole_pkts != '0);

endmodule

// File: rtl/lfc_fwd_policy.sv
module lfc_fwd_policy
  import lfc_pkg::*;
#(
  parameter int PKT_LEN = 4,
  parameter int CW      = 4
) (
  input  logic [1:0]    mode,
  input  logic          have_flit,
  input  logic [1:0]    front_kind,
  input  logic          in_pkt,
  input  logic          whole_avail,
  input  logic [CW-1:0] credits,
  output logic          go
);
  localparam logic [CW-1:0] PKT_CRED = CW'(PKT_LEN);

  logic room_flit, room_pkt;

  always_comb begin
    room_flit = (credits != '0);
    room_pkt  = (credits >= PKT_CRED);
    go        = 1'b0;
    if (have_flit) begin
      if (in_pkt || (front_kind != FK_HEAD)) begin
        go = room_flit;
      end else begin
        unique case (fwd_mode_e'(mode))
          FM_SAF:  go = whole_avail && room_pkt;
          FM_VCT:  go = room_pkt;
          default: go = room_flit;
        endcase
      end
    end
  end

endmodule

// File: rtl/lfc_link_ctrl.sv
module lfc_link_ctrl
  import lfc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PKT_LEN   = 4,
  parameter int BUF_DEPTH = 8,
  parameter int DS_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              credit_ret,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_data
);
  localparam int FW = DATA_W + 2;
  localparam int CW = $clog2(DS_DEPTH + 1);
  localparam int NW = $clog2(BUF_DEPTH + 1);

  logic          push, go, empty, full, in_pkt;
  logic [FW-1:0] front;
  logic [1:0]    front_kind;
  logic [CW-1:0] credits;
  logic [NW-1:0] whole_pkts;
  logic          front_head;

  assign in_ready   = !full;
  assign push       = in_valid && !full;
  assign front_kind = front[FW-1:FW-2];
  assign front_head = (front_kind == FK_HEAD);

  lfc_flit_fifo #(.W(FW), .DEPTH(BUF_DEPTH)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop     (go),
    .wr_data ({in_kind, in_data}),
    .rd_data (front),
    .empty   (empty),
    .full    (full)
  );

  lfc_credit_ctr #(.DS_DEPTH(DS_DEPTH), .CW(CW)) u_cred (
    .clk     (clk),
    .rst     (rst),
    .take    (go),
    .give    (credit_ret),
    .credits (credits)
  );

  lfc_pkt_tracker #(.BUF_DEPTH(BUF_DEPTH), .NW(NW)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .push_tail  (push && (in_kind == FK_TAIL)),
    .pop_head   (go && front_head),
    .pop_tail   (go && (front_kind == FK_TAIL)),
    .whole_pkts (whole_pkts),
    .in_pkt     (in_pkt)
  );

  lfc_fwd_policy #(.PKT_LEN(PKT_LEN), .CW(CW)) u_pol (
    .mode        (mode),
    .have_flit   (!empty),
    .front_kind  (front_kind),
    .in_pkt      (in_pkt),
    .whole_avail (whole_pkts != '0),
    .credits     (credits),
    .go          (go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= FK_BODY;
      out_data  <= '0;
    end else begin
      out_valid <= go;
      if (go) begin
        out_kind <= front_kind;
        out_data <= front[DATA_W-1:0];
      end
    end
  end

  // R2: a store-and-forward head leaves only with its whole packet local
  a_r2_saf_head_complete: assert property (@(posedge clk) disable iff (rst)
    (go && front_head && !in_pkt && mode == FM_SAF) |-> whole_pkts != '0);
  // R4: a cut-through head leaves only with whole-packet room downstream
  a_r4_vct_head_room: assert property (@(posedge clk) disable iff (rst)
    (go && front_head && !in_pkt && mode == FM_VCT) |-> credits >= CW'(PKT_LEN));
  // R1: output register mirrors the previous cycle's send decision
  a_r1_out_tracks_send: assert property (@(posedge clk) disable iff (rst)
    !go |=> !out_valid);

endmodule

// File: tb/lfc_link_ctrl_tb.sv
module lfc_link_ctrl_tb;
  import lfc_pkg::*;

  localparam int DATA_W    = 16;
  localparam int PKT_LEN   = 4;
  localparam int BUF_DEPTH = 8;
  localparam int DS_DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode = 2'd0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_kind = 2'd0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ready;
  logic              credit_ret = 1'b0;
  logic              out_valid;
  logic [1:0]        out_kind;
  logic [DATA_W-1:0] out_data;

  always #4 clk = ~clk; // 125 MHz

  lfc_link_ctrl #(.DATA_W(DATA_W), .PKT_LEN(PKT_LEN), .BUF_DEPTH(BUF_DEPTH),
                  .DS_DEPTH(DS_DEPTH)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_kind(in_kind),
    .in_data(in_data), .in_ready(in_ready), .credit_ret(credit_ret),
    .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data)
  );

  int errors = 0;
  int checks = 0;
  int outstanding = 0;
  int seq = 0;
  int n_out = 0;
  bit done = 0;
  logic [DATA_W+1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_of(input int pos);
    if (pos == 0) return FK_HEAD;
    if (pos == PKT_LEN - 1) return FK_TAIL;
    return FK_BODY;
  endfunction

  function automatic int exp_head_lat(input logic [1:0] m);
    return (m == FM_SAF) ? PKT_LEN : 1;
  endfunction

  function automatic int exp_tail_lat(input logic [1:0] m);
    return exp_head_lat(m) + PKT_LEN - 1;
  endfunction

  // sample outputs at the falling edge and score them
  task automatic tick();
    logic [DATA_W+1:0] e;
    @(negedge clk);
    if (!rst && out_valid) begin
      n_out++;
      outstanding++;
      chk(outstanding <= DS_DEPTH, "R6 unreturned flits", outstanding, DS_DEPTH);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected flit", int'(out_data), -1);
      end else begin
        e = exp_q.pop_front();
        chk({out_kind, out_data} == e, "R7 order/kind", int'({out_kind, out_data}), int'(e));
      end
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] k, input int d, input bit cr, output bit acc);
    in_valid   = v;
    in_kind    = k;
    in_data    = DATA_W'(d);
    credit_ret = cr;
    acc = v && in_ready;
    if (acc) exp_q.push_back({k, DATA_W'(d)});
    if (cr) outstanding--;
  endtask

  task automatic do_reset();
    bit acc;
    rst = 1'b1;
    drive(1'b0, FK_BODY, 0, 1'b0, acc);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    outstanding = 0;
  endtask

  task automatic run_pkt(input logic [1:0] m, input int ret_k, input int ret_n,
                         output int head_lat, output int tail_lat, output int nout);
    int fi;
    bit acc;
    head_lat = -1; tail_lat = -1; nout = 0; fi = 0;
    for (int k = 0; k < 40; k++) begin
      tick();
      if (out_valid) begin
        nout++;
        if (out_kind == FK_HEAD && head_lat < 0) head_lat = k - 1;
        if (out_kind == FK_TAIL && tail_lat < 0) tail_lat = k - 1;
      end
      mode = m;
      drive(fi < PKT_LEN, kind_of(fi), seq, (k >= ret_k) && (k < ret_k + ret_n), acc);
      if (acc) begin fi++; seq++; end
    end
    tick();
    drive(1'b0, FK_BODY, 0, 1'b0, acc);
  endtask

  task automatic give(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      tick();
      drive(1'b0, FK_BODY, 0, 1'b1, acc);
    end
    tick();
    drive(1'b0, FK_BODY, 0, 1'b0, acc);
  endtask

  task automatic burn();
    int h, t, n;
    for (int i = 0; i < DS_DEPTH / PKT_LEN; i++) run_pkt(FM_WH, 0, 0, h, t, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int h, t, n, cnt, rp;
    bit acc;
    logic [1:0] m;
    void'($urandom(32'd20240611));

    // R1 reset state
    do_reset();
    tick();
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R2 / R3 / R5 per-hop latency per mode with full credits (also R1 credits)
    for (int mi = 0; mi < 3; mi++) begin
      m = 2'(mi);
      do_reset();
      run_pkt(m, 0, 0, h, t, n);
      chk(h == exp_head_lat(m), (mi == 0) ? "R2 saf head latency" :
          (mi == 1) ? "R3 vct head latency" : "R5 wh head latency", h, exp_head_lat(m));
      chk(t == exp_tail_lat(m), "R2 R3 R5 tail latency", t, exp_tail_lat(m));
      chk(n == PKT_LEN, "R7 flits out", n, PKT_LEN);
    end

    // R4 cut-through head stalls with only two free slots
    do_reset();
    burn();
    give(2);
    run_pkt(FM_VCT, 6, 2, h, t, n);
    chk(h == 8, "R4 vct head waits for room", h, 8);
    chk(t == 11, "R4 vct tail", t, 11);
    chk(n == PKT_LEN, "R4 flits out", n, PKT_LEN);

    // R5 wormhole pauses mid-packet at zero credits; R6 returns resume it
    do_reset();
    burn();
    give(2);
    run_pkt(FM_WH, 8, 2, h, t, n);
    chk(h == 1, "R5 wh head", h, 1);
    chk(t == 10, "R5 wh tail after credits", t, 10);
    chk(n == PKT_LEN, "R6 flits out", n, PKT_LEN);

    // R8 full buffer refuses flits; R5 nothing moves at zero credits
    do_reset();
    burn();
    cnt = 0;
    n_out = 0;
    for (int i = 0; i <= BUF_DEPTH; i++) begin
      tick();
      mode = FM_WH;
      drive(1'b1, kind_of(i % PKT_LEN), seq, 1'b0, acc);
      if (acc) begin cnt++; seq++; end
    end
    tick();
    drive(1'b0, FK_BODY, 0, 1'b0, acc);
    chk(cnt == BUF_DEPTH, "R8 flits taken", cnt, BUF_DEPTH);
    chk(in_ready == 1'b0, "R8 in_ready when full", int'(in_ready), 0);
    chk(n_out == 0, "R5 no send at zero credits", n_out, 0);
    for (int i = 0; i < 40; i++) begin
      tick();
      drive(1'b0, FK_BODY, 0, outstanding > 0, acc);
    end
    chk(exp_q.size() == 0, "R8 drained exactly taken flits", exp_q.size(), 0);
    chk(n_out == BUF_DEPTH, "R8 refused flit never sent", n_out, BUF_DEPTH);

    // random modes, gaps and credit returns: R6 R7
    do_reset();
    n_out = 0;
    cnt = 0;
    rp = 0;
    for (int i = 0; i < 3000 || rp != 0; i++) begin
      tick();
      mode = 2'($urandom % 4);
      drive(($urandom % 10) < 7, kind_of(rp), seq, (outstanding > 0) && ($urandom % 2 == 1), acc);
      if (acc) begin
        seq++; cnt++;
        rp = (rp == PKT_LEN - 1) ? 0 : rp + 1;
      end
    end
    for (int i = 0; i < 300; i++) begin
      tick();
      drive(1'b0, FK_BODY, 0, outstanding > 0, acc);
    end
    chk(exp_q.size() == 0, "R7 random all delivered", exp_q.size(), 0);
    chk(n_out == cnt, "R7 random count", n_out, cnt);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule